// File: doc/BRIEF.md
# Break-Before-Make Switch Update Sequencer

This block drives a bank of independent switch enables. Each enable follows one bit of a control word, so any mix of switches may be on together, from none to all. A new word arrives with a one-cycle load strobe. The block compares that word with the enables it is driving now and moves to the new pattern without any instant in which a switch is turning on while another is still turning off.

Switches that must open are released on the first clock edge after the load. Switches that must close wait for a fixed number of system clocks after that release. A switch that is on in both the old and the new pattern is never dropped. If a load arrives while a sequence is still running, the word is held and started from the finished pattern. A later load replaces any word already held. A busy flag tells the control logic that an update is still settling.

Top module: `bbm_switch_sequencer`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `sw_en` is all zeros. `busy` is low whenever `load` is low and no update is running or held.
- R2: Bit i of a fully applied word drives `sw_en[i]` alone, for every pattern including all-ones (0xFF) and all-zeros (0x00).
- R3: A loaded word that turns no switch off appears in full on `sw_en` at the first clock edge after the load, with no wait.
- R4: A loaded word that turns at least one switch off first produces `old & new` on `sw_en` at the edge after the load. No edge ever both clears one enable and sets another.
- R5: In that case the bits that newly turn on appear exactly `GAP_CLKS` clock edges after the turn-off edge. No enable rises fewer than `GAP_CLKS` cycles after any enable fell.
- R6: A switch that is on before the load and on in the new word stays asserted on every cycle of the update.
- R7: `busy` is high in any cycle where `load` is high, an update is waiting out its gap, or a word is held. `sw_en` changes only after a cycle in which `busy` was high.
- R8: A load during a running update is held, and a later one replaces it. In the cycle after the running update completes, the held word starts its own sequence from the completed pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that commits `word` |
| word | input | N_SW | New switch pattern, bit i controls switch i |
| sw_en | output | N_SW | Switch enables |
| busy | output | 1 | Update in progress, held, or being loaded |

## Verification
The assertions check the following on every cycle: the reset value, the rule that no edge both sets and clears enables, the minimum gap between any fall and any following rise, and the rule that enables move only after a busy cycle. They do not know the target word. For that reason, the exact intermediate pattern, the preservation of switches that stay on, the immediate path for words that only add switches, and the replacement of a held word by a later one are shown only by the bench. The bench compares its reference model against the design on every clock and adds directed checks at the turn-off and turn-on edges.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_GAP  = 1'b1
   } seq_state_t;
endpackage

// File: rtl/bbm_bit_compare.sv
// Per-switch comparison of the driven pattern against a candidate word.
module bbm_bit_compare #(
   parameter int N_SW = 8
) (
   input  logic [N_SW-1:0] cur,
   input  logic [N_SW-1:0] nxt,
   output logic [N_SW-1:0] keep_mask,
   output logic            drop_any
);
   logic [N_SW-1:0] drop_mask;

   for (genvar i = 0; i < N_SW; i++) begin : g_bit
      assign keep_mask[i] = cur[i] & nxt[i];
      assign drop_mask[i] = cur[i] & ~nxt[i];
   end

   assign drop_any = |drop_mask;
endmodule

// File: rtl/bbm_gap_timer.sv
// Counts the dead time between release and engage.
module bbm_gap_timer #(
   parameter int GAP_CLKS = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic expired
);
   if (GAP_CLKS < 1) begin : g_bad_gap
      $error("bbm_gap_timer: GAP_CLKS must be at least 1");
   end

   if (GAP_CLKS == 1) begin : g_single
      // One cycle of dead time is simply the state register itself.
      assign expired = 1'b1;
   end else begin : g_count
      localparam int CNT_W = $clog2(GAP_CLKS);
      localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(GAP_CLKS - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q <= '0;
         end else if (start) begin
            cnt_q <= LOAD_V;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign expired = (cnt_q == '0);
   end
endmodule

// File: rtl/bbm_pend_slot.sv
// Single-entry holding slot for a word that arrives mid-sequence.
module bbm_pend_slot #(
   parameter int N_SW = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            capture,
   input  logic [N_SW-1:0] data,
   input  logic            consume,
   output logic            valid,
   output logic [N_SW-1:0] held
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         held  <= '0;
      end else if (capture) begin
         valid <= 1'b1;
         held  <= data;
      end else if (consume) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/bbm_switch_sequencer.sv
module bbm_switch_sequencer
   import bbm_pkg::*;
#(
   parameter int N_SW     = 8,
   parameter int GAP_CLKS = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [N_SW-1:0] word,
   output logic [N_SW-1:0] sw_en,
   output logic            busy
);
   if (N_SW < 1) begin : g_bad_width
      $error("bbm_switch_sequencer: N_SW must be at least 1");
   end

   seq_state_t      state_q;
   logic [N_SW-1:0] en_q;
   logic [N_SW-1:0] target_q;

   logic            pend_valid;
   logic [N_SW-1:0] pend_word;
   logic [N_SW-1:0] src_word;
   logic            src_valid;
   logic [N_SW-1:0] keep_mask;
   logic            drop_any;
   logic            gap_done;
   logic            timer_start;
   logic            in_idle;

   assign in_idle     = (state_q == SEQ_IDLE);
   // A fresh strobe overrides a held word.
   assign src_word    = load ? word : pend_word;
   assign src_valid   = load | pend_valid;
   assign timer_start = in_idle & src_valid & drop_any;

   bbm_bit_compare #(.N_SW(N_SW)) u_cmp (
      .cur       (en_q),
      .nxt       (src_word),
      .keep_mask (keep_mask),
      .drop_any  (drop_any)
   );

   bbm_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .start   (timer_start),
      .expired (gap_done)
   );

   bbm_pend_slot #(.N_SW(N_SW)) u_pend (
      .clk     (clk),
      .rst     (rst),
      .capture (~in_idle & load),
      .data    (word),
      .consume (in_idle & pend_valid),
      .valid   (pend_valid),
      .held    (pend_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= SEQ_IDLE;
         en_q     <= '0;
         target_q <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (src_valid) begin
                  target_q <= src_word;
                  if (drop_any) begin
                     en_q    <= keep_mask;
                     state_q <= SEQ_GAP;
                  end else begin
                     en_q <= src_word;
                  end
               end
            end
            SEQ_GAP: begin
               if (gap_done) begin
                  en_q    <= target_q;
                  state_q <= SEQ_IDLE;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign sw_en = en_q;
   assign busy  = ~in_idle | pend_valid | load;
endmodule

// File: rtl/bbm_switch_sequencer_checker.sv
module bbm_switch_sequencer_checker #(
   parameter int N_SW     = 8,
   parameter int GAP_CLKS = 3
) (
   input logic            clk,
   input logic            rst,
   input logic [N_SW-1:0] sw_en,
   input logic            busy
);
   localparam int SW = $clog2(GAP_CLKS + 1) + 1;
   localparam logic [SW-1:0] GAP_V = SW'(GAP_CLKS);

   logic [N_SW-1:0] prev_en;
   logic [SW-1:0]   since_off;
   logic            fell_now;
   logic            rose_now;

   assign fell_now = |(prev_en & ~sw_en);
   assign rose_now = |(~prev_en & sw_en);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_en   <= '0;
         since_off <= GAP_V;
      end else begin
         prev_en <= sw_en;
         if (fell_now) begin
            since_off <= SW'(1);
         end else if (since_off < GAP_V) begin
            since_off <= since_off + 1'b1;
         end
      end
   end

   assert_reset_off_R1: assert property (@(posedge clk)
      rst |=> (sw_en == '0));

   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
      !(rose_now && fell_now));

   assert_gap_R5: assert property (@(posedge clk) disable iff (rst)
      rose_now |-> (since_off >= GAP_V));

   assert_move_busy_R7: assert property (@(posedge clk) disable iff (rst)
      !$stable(sw_en) |-> $past(busy));
endmodule

bind bbm_switch_sequencer bbm_switch_sequencer_checker #(
   .N_SW     (N_SW),
   .GAP_CLKS (GAP_CLKS)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .sw_en (sw_en),
   .busy  (busy)
);

// File: tb/bbm_switch_sequencer_bench.sv
module bbm_switch_sequencer_bench;
   localparam int N   = 8;
   localparam int GAP = 3;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load = 1'b0;
   logic [N-1:0] word = '0;
   logic [N-1:0] sw_en;
   logic         busy;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   string phase_tag = "R1";
   logic [N-1:0] hold_mask = '0;

   always #10 clk = ~clk;

   bbm_switch_sequencer #(.N_SW(N), .GAP_CLKS(GAP)) u_bbm_switch_sequencer (
      .clk(clk), .rst(rst), .load(load), .word(word), .sw_en(sw_en), .busy(busy)
   );

   // Behavioural reference model
   logic [N-1:0] m_en = '0;
   logic [N-1:0] m_target = '0;
   bit           m_wait = 1'b0;
   int           m_left = 0;
   logic [N-1:0] m_q[$];

   always @(posedge clk) begin
      if (rst) begin
         m_en = '0; m_wait = 1'b0; m_left = 0; m_q.delete();
      end else if (m_wait) begin
         if (load) begin m_q.delete(); m_q.push_back(word); end
         if (m_left == 0) begin m_en = m_target; m_wait = 1'b0; end
         else m_left = m_left - 1;
      end else if (load || m_q.size() != 0) begin
         logic [N-1:0] w;
         w = load ? word : m_q[0];
         m_q.delete();
         if ((m_en & ~w) != '0) begin
            m_en = m_en & w; m_target = w; m_wait = 1'b1; m_left = GAP - 1;
         end else begin
            m_en = w;
         end
      end
   end

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         chk({phase_tag, " sw_en vs model"}, sw_en, m_en);
         chk("R7 busy vs model", N'(busy),
             N'(m_wait || m_q.size() != 0 || load));
         if (hold_mask != '0) chk("R6 kept switches", sw_en & hold_mask, hold_mask);
      end
   end

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic pulse(input logic [N-1:0] w);
      edges(1); load = 1'b1; word = w;
      edges(1); load = 1'b0;
   endtask

   initial begin
      edges(1);
      chk("R1 reset sw_en", sw_en, '0);
      edges(2);
      rst = 1'b0;
      #6;
      chk("R1 sw_en after reset", sw_en, '0);
      chk("R1 busy idle", N'(busy), '0);

      phase_tag = "R3";
      pulse(8'hFF);
      chk("R3 add-only applied next edge", sw_en, 8'hFF);
      chk("R2 all ones", sw_en, 8'hFF);

      phase_tag = "R4";
      hold_mask = 8'h0F;
      pulse(8'h0F);
      chk("R4 release only", sw_en, 8'h0F);
      edges(GAP + 1);
      hold_mask = '0;

      phase_tag = "R5";
      pulse(8'hF0);
      chk("R4 intermediate old&new", sw_en, 8'h00);
      chk("R7 busy during gap", N'(busy), 8'h01);
      edges(GAP - 1);
      chk("R5 still off before gap ends", sw_en, 8'h00);
      edges(1);
      chk("R5 engaged after gap", sw_en, 8'hF0);

      phase_tag = "R6";
      hold_mask = 8'hA0;
      pulse(8'hA5);
      chk("R6 intermediate keeps common", sw_en, 8'hA0);
      edges(GAP);
      chk("R6 final pattern", sw_en, 8'hA5);
      hold_mask = '0;
      edges(1);

      phase_tag = "R8";
      pulse(8'h3C);
      chk("R8 first intermediate", sw_en, 8'h24);
      load = 1'b1; word = 8'h11;
      edges(1); word = 8'h81;
      edges(1); load = 1'b0;
      edges(1);
      chk("R8 first word completed", sw_en, 8'h3C);
      chk("R8 busy with held word", N'(busy), 8'h01);
      edges(1);
      chk("R8 held word release (last wins)", sw_en, 8'h00);
      edges(GAP);
      chk("R8 held word applied", sw_en, 8'h81);
      edges(1);
      chk("R8 busy clears", N'(busy), 8'h00);

      phase_tag = "R2";
      pulse(8'h00);
      chk("R2 all zeros", sw_en, 8'h00);
      edges(GAP + 2);
      pulse(8'h5A);
      chk("R2 mixed pattern", sw_en, 8'h5A);
      edges(3);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule